// File: doc/BRIEF.md
# Selectable Clock Divider with Odd Ratios

This block derives a slower clock, together with a one-cycle clock-enable tick, from a single input clock. A select code picks one of the even ratios 2, 4, 6, 8, 10, 12, 14 or 16. Setting the odd-mode input turns the 6, 10 and 14 settings into 3, 5 and 7. In odd mode the counter runs over the halved ratio, and a falling-edge register together with an output mux shapes the high phase in half-cycle steps. The odd-ratio output is evenly spaced only when the input clock has a 50% duty cycle.

An external synchronous restart input pins the divided output to a known phase. A new ratio is picked up only at the start of a period, so the output never shows a truncated period. The tick output stays high for the first input cycle of every divided period. Logic running on the input clock can use it as an enable in place of the divided clock.

Top module: `clk_div_sel`

## Requirements
- R1: While `rst_ni` is low, `div_clk_o` and `tick_o` are 0. The first rising edge after release starts a new period with the ratio selected at that edge.
- R2: With `odd_en_i` low and code s in 0..7 (the default `NUM_RATIOS` = 8), the period is 2*(s+1) input cycles. `div_clk_o` is high for the first s+1 cycles and low for the rest, and it changes only just after rising edges.
- R3: Codes 8 to 15 select divide-by-2 whatever the value of `odd_en_i`.
- R4: With `odd_en_i` high and code 2, 4 or 6, the period is M = 3, 5 or 7 cycles. `div_clk_o` rises at the falling edge inside cycle 0 and falls at the rising edge that starts cycle (M+1)/2, so it is high for M/2 cycles.
- R5: With `odd_en_i` high, any code other than 2, 4 or 6 gives the even ratio of R2 or R3.
- R6: `tick_o` is high for exactly cycle 0 of each period and low in every other cycle.
- R7: A rising edge that samples `sync_rst_i` high makes the following cycle cycle 0 of a new period with the currently selected ratio. Holding `sync_rst_i` high restarts the period at every edge.
- R8: Changes to `div_sel_i` and `odd_en_i` take effect only at the rising edge that starts a new period, whether that period starts by wrap or by restart. Inside a period, the length and high time stay as they were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, used on both edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous period restart for phase alignment |
| odd_en_i | input | 1 | Odd-ratio mode request |
| div_sel_i | input | 4 | Divide-select code |
| div_clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle enable at the start of each period |

## Verification
The bench builds the block with its defaults: eight even ratios, a 4-bit select code and odd support enabled. The 4-bit code reaches eight unused codes, so the divide-by-2 fallback can be exercised alongside every legal ratio. With odd support built, the falling-edge register is present, so the bench checks each output half-cycle. This covers the mode switches between even and odd, restarts inside a period, and select changes that must wait for a period boundary.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

   // Counter width shared by all stages; holds ratios up to 255.
   localparam int CNT_W = 8;

   typedef enum logic {
      DIV_EVEN = 1'b0,
      DIV_ODD  = 1'b1
   } div_mode_e;

   // Active divider setting: last count of the period, number of
   // rising-edge cycles the primary phase is high, and shaping mode.
   typedef struct packed {
      logic [CNT_W-1:0] term;
      logic [CNT_W-1:0] hi;
      div_mode_e        mode;
   } div_cfg_t;

   localparam div_cfg_t CFG_RESET = '{term: CNT_W'(1), hi: CNT_W'(1), mode: DIV_EVEN};

endpackage

// File: rtl/cdiv_decode.sv
`timescale 1ns/1ps
module cdiv_decode
   import cdiv_pkg::*;
#(
   parameter int NUM_RATIOS = 8,
   parameter int SEL_W      = 4,
   parameter bit ODD_EN     = 1'b1
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic             odd_i,
   output div_cfg_t         cfg_o
);

   localparam int CW = CNT_W;

   logic [CW-1:0] sel_ext;
   logic [CW-1:0] even_n;
   logic [CW-1:0] half_n;
   logic          legal_code;
   logic          odd_ok;

   initial begin
      AST_SEL_FITS_COUNTER : assert (SEL_W < CW)
         else $error("select width must be below the counter width");
   end

   assign sel_ext    = CW'(sel_i);
   assign legal_code = (int'(sel_i) < NUM_RATIOS);
   assign even_n     = legal_code ? ((sel_ext + CW'(1)) << 1) : CW'(2);
   assign half_n     = even_n >> 1;

   generate
      if (ODD_EN) begin : g_odd
         // Halved ratio must itself be odd and at least 3.
         assign odd_ok = odd_i && half_n[0] && (half_n >= CW'(3));
      end else begin : g_even_only
         assign odd_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (odd_ok) begin
         cfg_o.term = half_n - CW'(1);
         cfg_o.hi   = (half_n + CW'(1)) >> 1;
         cfg_o.mode = DIV_ODD;
      end else begin
         cfg_o.term = even_n - CW'(1);
         cfg_o.hi   = half_n;
         cfg_o.mode = DIV_EVEN;
      end
   end

   always_comb begin
      if (!$isunknown({sel_i, odd_i})) begin
         AST_HI_BELOW_TERM : assert (cfg_o.hi <= cfg_o.term) else $error("high phase covers the whole period"); // R2
      end
   end

endmodule

// File: rtl/cdiv_count.sv
`timescale 1ns/1ps
module cdiv_count
   import cdiv_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      sync_rst_i,
   input  div_cfg_t  cfg_i,
   output logic      phase_o,
   output logic      tick_o,
   output div_mode_e mode_o
);

   localparam int CW = CNT_W;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   div_cfg_t      cfg_q;
   logic          wrap;

   assign cnt_inc = cnt_q + CW'(1);
   // Reset value all-ones is at or past any terminal count, so the
   // first edge after reset opens a fresh period.
   assign wrap    = sync_rst_i || (cnt_q >= cfg_q.term);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '1;
         cfg_q   <= CFG_RESET;
         phase_o <= 1'b0;
         tick_o  <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         cfg_q   <= cfg_i;
         phase_o <= 1'b1;
         tick_o  <= 1'b1;
      end else begin
         cnt_q   <= cnt_inc;
         phase_o <= (cnt_inc < cfg_q.hi);
         tick_o  <= 1'b0;
      end
   end

   assign mode_o = cfg_q.mode;

   AST_SYNC_RESTART : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_rst_i |=> (tick_o && cnt_q == '0)) else $error("restart missed"); // R7
   AST_CFG_HELD : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_rst_i && cnt_q < cfg_q.term) |=> $stable(cfg_q)) else $error("ratio changed mid-period"); // R8
   AST_TICK_SINGLE : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && !sync_rst_i) |=> !tick_o) else $error("tick wider than a cycle"); // R6
   AST_WRAP_TICK : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_rst_i && cnt_q >= cfg_q.term) |=> tick_o) else $error("no tick at wrap"); // R6
   AST_TICK_IN_HIGH : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> phase_o) else $error("tick outside high phase"); // R2
   AST_ODD_TERM : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.mode == DIV_ODD) |-> (!cfg_q.term[0] && cfg_q.term >= CW'(2))) else $error("bad odd ratio"); // R4

endmodule

// File: rtl/cdiv_dual_edge.sv
`timescale 1ns/1ps
module cdiv_dual_edge
   import cdiv_pkg::*;
#(
   parameter bit ODD_EN = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      phase_i,
   input  div_mode_e mode_i,
   output logic      div_clk_o
);

   generate
      if (ODD_EN) begin : g_dual
         logic fall_q;
         // Falling-edge copy of the rising-edge phase; the output mux
         // trims half a cycle from the leading side in odd mode.
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) fall_q <= 1'b0;
            else         fall_q <= phase_i;
         end
         assign div_clk_o = (mode_i == DIV_ODD) ? (phase_i & fall_q) : phase_i;
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = mode_i;
         assign div_clk_o   = phase_i;
      end
   endgenerate

   AST_OUT_WITHIN_PHASE : assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_clk_o |-> phase_i) else $error("output high outside phase"); // R4

endmodule

// File: rtl/clk_div_sel.sv
`timescale 1ns/1ps
module clk_div_sel
   import cdiv_pkg::*;
#(
   parameter int NUM_RATIOS = 8,
   parameter int SEL_W      = 4,
   parameter bit ODD_EN     = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_rst_i,
   input  logic             odd_en_i,
   input  logic [SEL_W-1:0] div_sel_i,
   output logic             div_clk_o,
   output logic             tick_o
);

   localparam int MAX_RATIO = 2 * NUM_RATIOS;

   initial begin
      AST_RATIO_COUNT : assert (NUM_RATIOS >= 1) else $error("need at least one ratio");
      AST_SEL_COVERS  : assert ((1 << SEL_W) >= NUM_RATIOS) else $error("select too narrow");
      AST_CNT_COVERS  : assert (MAX_RATIO < (1 << CNT_W)) else $error("ratio exceeds counter");
   end

   div_cfg_t  cfg_sel;
   div_mode_e mode;
   logic      phase;

   cdiv_decode #(
      .NUM_RATIOS (NUM_RATIOS),
      .SEL_W      (SEL_W),
      .ODD_EN     (ODD_EN)
   ) u_decode (
      .sel_i (div_sel_i),
      .odd_i (odd_en_i),
      .cfg_o (cfg_sel)
   );

   cdiv_count u_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_rst_i (sync_rst_i),
      .cfg_i      (cfg_sel),
      .phase_o    (phase),
      .tick_o     (tick_o),
      .mode_o     (mode)
   );

   cdiv_dual_edge #(
      .ODD_EN (ODD_EN)
   ) u_shape (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .phase_i   (phase),
      .mode_i    (mode),
      .div_clk_o (div_clk_o)
   );

endmodule

// File: tb/tb_clk_div_sel.sv
`timescale 1ns/1ps
module tb_clk_div_sel;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sync_rst;
   logic       odd_en;
   logic [3:0] sel;
   logic       div_clk;
   logic       tick;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   int    mk, mlen, mhi;
   bit    modd, mp, mprev;
   string mtag, tag_ov;

   always #2.5 clk = ~clk;

   clk_div_sel dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .sync_rst_i (sync_rst),
      .odd_en_i   (odd_en),
      .div_sel_i  (sel),
      .div_clk_o  (div_clk),
      .tick_o     (tick)
   );

   function automatic void expect_cfg(input int s, input bit o,
                                      output int len, output int hi, output bit od);
      int n;
      n = (s < 8) ? 2 * (s + 1) : 2;
      if (o && (n % 4 == 2) && n >= 6) begin
         len = n / 2; hi = (len + 1) / 2; od = 1'b1;
      end else begin
         len = n; hi = n / 2; od = 1'b0;
      end
   endfunction

   task automatic check(input bit got, input bit exp, input string tag, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, got, exp);
      end
   endtask

   function automatic string cur_tag();
      return (tag_ov != "") ? tag_ov : mtag;
   endfunction

   task automatic step();
      @(posedge clk);
      mprev = mp;
      if (sync_rst || mk >= mlen - 1) begin
         expect_cfg(int'(sel), odd_en, mlen, mhi, modd);
         mtag = modd ? "R4" : (sel >= 8) ? "R3" : odd_en ? "R5" : "R2";
         mk = 0;
      end else begin
         mk++;
      end
      mp = (mk < mhi);
      #1;
      check(tick, (mk == 0), (tag_ov != "") ? tag_ov : "R6", "tick");
      check(div_clk, modd ? (mp && mprev) : mp, cur_tag(), "div_clk early half");
      @(negedge clk);
      #1;
      check(div_clk, mp, cur_tag(), "div_clk late half");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c1d));
      tag_ov = ""; mtag = "R2";
      rst_n = 1'b0; sync_rst = 1'b0; odd_en = 1'b0; sel = 4'd3;
      mk = 1; mlen = 2; mhi = 1; modd = 1'b0; mp = 1'b0; mprev = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(div_clk, 1'b0, "R1", "div_clk in reset");
      check(tick, 1'b0, "R1", "tick in reset");
      rst_n = 1'b1;
      tag_ov = "R1";
      step();
      tag_ov = "";
      repeat (12) step();

      // every code, even mode (R2, R3)
      for (int s = 0; s < 16; s++) begin
         sel = 4'(s); odd_en = 1'b0;
         repeat (40) step();
      end
      // odd requests: legal (R4) and ignored (R5, R3)
      for (int s = 0; s < 16; s++) begin
         sel = 4'(s); odd_en = 1'b1;
         repeat (36) step();
      end

      // R7: restart mid-period, then held
      sel = 4'd7; odd_en = 1'b0;
      repeat (20) step();
      tag_ov = "R7";
      sync_rst = 1'b1; step();
      sync_rst = 1'b0; repeat (5) step();
      sync_rst = 1'b1; repeat (3) step();
      sel = 4'd4; odd_en = 1'b1; step();
      sync_rst = 1'b0; repeat (12) step();

      // R8: selection change inside a period waits for the wrap
      sel = 4'd7; odd_en = 1'b0;
      sync_rst = 1'b1; step(); sync_rst = 1'b0;
      tag_ov = "R8";
      repeat (2) step();
      sel = 4'd0;
      repeat (20) step();
      sel = 4'd6; odd_en = 1'b1; step();
      sel = 4'd1; odd_en = 1'b0;
      repeat (12) step();
      tag_ov = "";

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(19) == 0) sel = 4'($urandom_range(15));
         if ($urandom_range(29) == 0) odd_en = ($urandom_range(1) == 1);
         sync_rst = ($urandom_range(49) == 0);
         step();
      end
      sync_rst = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule